// File: doc/BRIEF.md
# Super I/O Index/Data Configuration Port

This block is the configuration front end of an on-chip Super I/O controller. Software sees two consecutive byte addresses. Offset 0 is the index port, and it chooses one of 256 configuration bytes. Offset 1 is the data port, and it reads or writes the byte that the index chooses. The index is not a separate register. It lives in configuration slot 0, so a data-port write while the index is 0 replaces the index.

The parent bridge owns a decode-enable bit that switches the port pair on or off. After reset the decode is off.

The block holds the whole register file and loads the reset defaults. It drives the function-select byte and the four device base-address bytes to the serial, parallel and floppy controllers, which sit outside this block.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset these bytes hold these values: 0xE0=0x3C, 0xE2=0x03, 0xE3=0xFC, 0xE6=0xDE, 0xE7=0xFE, 0xE8=0xBE. Every other byte, including the index slot 0, holds 0. The decode is off until `dec_en` is 1.
- R2: A byte write to offset 0 (`acc_off`=0) sets the index. A read of offset 0 returns the current index.
- R3: A byte write to offset 1 stores `acc_wdata` at the indexed byte. Every read access, accepted or not, raises `rd_vld` for one cycle on the next clock, with the result on `rd_data`. `rd_data` holds its value between reads.
- R4: A data-port read while the index is 0 returns 0x00. A data-port write while the index is 0 replaces the index.
- R5: Data-port writes to the read-only bytes 0xE0 (device ID) and 0xE1 (revision) are dropped and leave them unchanged.
- R6: Only accesses with `acc_size`=0 (one byte) are accepted. Size 1 (two bytes) and size 2 or 3 (four bytes) are ignored: a write changes nothing, and a read returns 0xFF.
- R7: While `dec_en` is 0, reads return 0xFF and writes change nothing, not even the index.
- R8: A data-port write to an index outside {0x00, 0xE0, 0xE1, 0xE2, 0xE3, 0xE6, 0xE7, 0xE8} still stores the byte and raises `unimpl_pulse` for exactly the following cycle.
- R9: `fn_sel`, `fdc_base`, `lpt_base`, `com1_base` and `com2_base` always show bytes 0xE2, 0xE3, 0xE6, 0xE7 and 0xE8. Each updates on the clock that accepts a write to it, and changes at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dec_en | input | 1 | Decode enable from the parent bridge |
| acc_vld | input | 1 | Access strobe, one cycle per access |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_off | input | 1 | 0 = index port, 1 = data port |
| acc_size | input | 2 | Access size: 0 byte, 1 two bytes, 2/3 four bytes |
| acc_wdata | input | 8 | Write data |
| rd_vld | output | 1 | Read result valid (one cycle) |
| rd_data | output | 8 | Read result |
| unimpl_pulse | output | 1 | One-cycle flag for a write to an undefined byte |
| fn_sel | output | 8 | Function-select byte (0xE2) |
| fdc_base | output | 8 | Floppy base byte (0xE3) |
| lpt_base | output | 8 | Parallel base byte (0xE6) |
| com1_base | output | 8 | Serial 1 base byte (0xE7) |
| com2_base | output | 8 | Serial 2 base byte (0xE8) |

## Verification
The assertions check these behaviours on every cycle:
- the one-cycle read latency;
- the 0xFF result of a disabled read;
- the frozen field outputs after a disabled access, a wrongly sized access or an idle cycle;
- that `unimpl_pulse` follows only an accepted data-port write.

Some behaviours depend on the stored index and on data values, and only the bench's scenarios can show them. These are the index living in slot 0, the zero returned for index 0, dropped writes to the read-only bytes, and storage at undefined addresses. The bench's reference model covers them, together with the reset defaults.

// File: rtl/sio_cfg_pkg.sv
// Package: shared definitions for the Super I/O configuration port.
// It holds the byte addresses of the defined configuration bytes, the
// per-byte reset value and the class of each byte address.
// Assumes 8-bit configuration bytes and index values below 256.
package sio_cfg_pkg;

    localparam int ADR_INDEX = 'h00;
    localparam int ADR_DEVID = 'hE0;
    localparam int ADR_REV   = 'hE1;
    localparam int ADR_FSEL  = 'hE2;
    localparam int ADR_FDC   = 'hE3;
    localparam int ADR_LPT   = 'hE6;
    localparam int ADR_COM1  = 'hE7;
    localparam int ADR_COM2  = 'hE8;

    localparam logic [1:0] SZ_BYTE = 2'd0;

    typedef enum logic [1:0] {
        RC_INDEX,
        RC_RO,
        RC_DEF,
        RC_FREE
    } reg_class_e;

    // Reset value of configuration byte a.
    function automatic logic [7:0] reset_value(input int a);
        case (a)
            ADR_DEVID: reset_value = 8'h3C;
            ADR_FSEL:  reset_value = 8'h03;
            ADR_FDC:   reset_value = 8'hFC;
            ADR_LPT:   reset_value = 8'hDE;
            ADR_COM1:  reset_value = 8'hFE;
            ADR_COM2:  reset_value = 8'hBE;
            default:   reset_value = 8'h00;
        endcase
    endfunction

    // Class of byte a: index slot, read-only, defined, or free storage.
    function automatic reg_class_e classify(input int a);
        case (a)
            ADR_INDEX:        classify = RC_INDEX;
            ADR_DEVID,
            ADR_REV:          classify = RC_RO;
            ADR_FSEL,
            ADR_FDC,
            ADR_LPT,
            ADR_COM1,
            ADR_COM2:         classify = RC_DEF;
            default:          classify = RC_FREE;
        endcase
    endfunction

endpackage

// File: rtl/sio_cfg_decode.sv
// Module: sio_cfg_decode
// Qualifies a host access and turns it into one write command for the
// register file. An access is accepted only when decode is enabled and
// the size is one byte. An index-port write targets slot 0. A data-port
// write targets the current index, unless that index is read-only.
// Registers the flag for a write to an undefined byte.
// Assumes the index is already held in slot 0 (cur_idx).
module sio_cfg_decode
    import sio_cfg_pkg::*;
#(
    parameter int NREG = 256,
    parameter int IW   = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dec_en,
    input  logic          acc_vld,
    input  logic          acc_wr,
    input  logic          acc_off,
    input  logic [1:0]    acc_size,
    input  logic [IW-1:0] cur_idx,
    output logic          acc_ok,
    output logic          wr_en,
    output logic [IW-1:0] wr_sel,
    output logic          unimpl_pulse
);

    reg_class_e cls;

    // Accept check and write target selection.
    always_comb begin
        acc_ok = dec_en && acc_vld && (acc_size == SZ_BYTE);
        cls    = classify(int'(cur_idx));
        wr_sel = acc_off ? cur_idx : '0;
        wr_en  = acc_ok && acc_wr && (!acc_off || (cls != RC_RO));
    end

    // One-cycle flag for an accepted data write to an undefined byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unimpl_pulse <= 1'b0;
        end else begin
            unimpl_pulse <= acc_ok && acc_wr && acc_off && (cls == RC_FREE);
        end
    end

endmodule

// File: rtl/sio_cfg_regfile.sv
// Module: sio_cfg_regfile
// Storage for all configuration bytes, one register per byte, each with
// its own reset value. Has a single write port and exposes every byte.
// Assumes the write command has already been qualified.
module sio_cfg_regfile
    import sio_cfg_pkg::*;
#(
    parameter int NREG = 256,
    parameter int DW   = 8,
    parameter int IW   = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_sel,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] regs [NREG]
);

    for (genvar g = 0; g < NREG; g++) begin : g_slot
        // Byte g: reset value, or the write data when this byte is selected.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs[g] <= DW'(reset_value(g));
            end else if (wr_en && (wr_sel == IW'(g))) begin
                regs[g] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/sio_cfg_rdmux.sv
// Module: sio_cfg_rdmux
// Read path. On the clock after any read access it registers the result
// and raises rd_vld for one cycle. The result is 0xFF for a rejected
// access, the index for offset 0, 0 for data at index 0, or the indexed
// byte. rd_data holds its value between reads.
// Assumes slot 0 holds the index.
module sio_cfg_rdmux #(
    parameter int NREG = 256,
    parameter int DW   = 8,
    parameter int IW   = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_vld,
    input  logic          acc_wr,
    input  logic          acc_off,
    input  logic          acc_ok,
    input  logic [IW-1:0] cur_idx,
    input  logic [DW-1:0] regs [NREG],
    output logic          rd_vld,
    output logic [DW-1:0] rd_data
);

    logic [DW-1:0] sel_val;
    logic          rd_req;

    // Choose the value a read would return.
    always_comb begin
        rd_req = acc_vld && !acc_wr;
        if (!acc_ok) begin
            sel_val = '1;
        end else if (!acc_off) begin
            sel_val = regs[0];
        end else if (cur_idx == '0) begin
            sel_val = '0;
        end else begin
            sel_val = regs[cur_idx];
        end
    end

    // Register the read result and its valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_vld  <= 1'b0;
            rd_data <= '0;
        end else begin
            rd_vld <= rd_req;
            if (rd_req) begin
                rd_data <= sel_val;
            end
        end
    end

endmodule

// File: rtl/sio_cfg_port.sv
// Module: sio_cfg_port (top)
// Index/data configuration port pair for a Super I/O. Joins the access
// decoder, the register file and the read path. Drives the function
// select byte and the device base bytes to the device controllers.
// Assumes one access strobe per cycle at most, from a single host.
module sio_cfg_port
    import sio_cfg_pkg::*;
#(
    parameter int NREG = 256,
    parameter int DW   = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dec_en,
    input  logic          acc_vld,
    input  logic          acc_wr,
    input  logic          acc_off,
    input  logic [1:0]    acc_size,
    input  logic [DW-1:0] acc_wdata,
    output logic          rd_vld,
    output logic [DW-1:0] rd_data,
    output logic          unimpl_pulse,
    output logic [DW-1:0] fn_sel,
    output logic [DW-1:0] fdc_base,
    output logic [DW-1:0] lpt_base,
    output logic [DW-1:0] com1_base,
    output logic [DW-1:0] com2_base
);

    localparam int IW = $clog2(NREG);

    logic [DW-1:0] regs [NREG];
    logic [IW-1:0] cur_idx;
    logic          acc_ok;
    logic          wr_en;
    logic [IW-1:0] wr_sel;

    // The index lives in slot 0.
    always_comb cur_idx = regs[0][IW-1:0];

    sio_cfg_decode #(.NREG(NREG), .IW(IW)) i_decode (
        .clk          (clk),
        .rst_n        (rst_n),
        .dec_en       (dec_en),
        .acc_vld      (acc_vld),
        .acc_wr       (acc_wr),
        .acc_off      (acc_off),
        .acc_size     (acc_size),
        .cur_idx      (cur_idx),
        .acc_ok       (acc_ok),
        .wr_en        (wr_en),
        .wr_sel       (wr_sel),
        .unimpl_pulse (unimpl_pulse)
    );

    sio_cfg_regfile #(.NREG(NREG), .DW(DW), .IW(IW)) i_regfile (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (acc_wdata),
        .regs    (regs)
    );

    sio_cfg_rdmux #(.NREG(NREG), .DW(DW), .IW(IW)) i_rdmux (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc_vld (acc_vld),
        .acc_wr  (acc_wr),
        .acc_off (acc_off),
        .acc_ok  (acc_ok),
        .cur_idx (cur_idx),
        .regs    (regs),
        .rd_vld  (rd_vld),
        .rd_data (rd_data)
    );

    // Field outputs taken from the defined bytes.
    always_comb begin
        fn_sel    = regs[ADR_FSEL];
        fdc_base  = regs[ADR_FDC];
        lpt_base  = regs[ADR_LPT];
        com1_base = regs[ADR_COM1];
        com2_base = regs[ADR_COM2];
    end

endmodule

// File: rtl/sio_cfg_port_chk.sv
// Module: sio_cfg_port_chk
// Port-level checker bound to sio_cfg_port.
module sio_cfg_port_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          dec_en,
    input logic          acc_vld,
    input logic          acc_wr,
    input logic          acc_off,
    input logic [1:0]    acc_size,
    input logic [DW-1:0] acc_wdata,
    input logic          rd_vld,
    input logic [DW-1:0] rd_data,
    input logic          unimpl_pulse,
    input logic [DW-1:0] fn_sel,
    input logic [DW-1:0] fdc_base,
    input logic [DW-1:0] lpt_base,
    input logic [DW-1:0] com1_base,
    input logic [DW-1:0] com2_base
);

    logic [5*DW-1:0] fields;
    always_comb fields = {fn_sel, fdc_base, lpt_base, com1_base, com2_base};

    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld && !acc_wr) |=> rd_vld); // R3
    AST_RD_ONLY_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_vld |-> $past(acc_vld && !acc_wr)); // R3
    AST_RD_DISABLED_FF: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld && !acc_wr && !dec_en) |=> (rd_data == '1)); // R7
    AST_WR_DISABLED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld && acc_wr && !dec_en) |=> $stable(fields)); // R7
    AST_BADSIZE_RD_FF: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld && !acc_wr && (acc_size != 2'd0)) |=> (rd_data == '1)); // R6
    AST_BADSIZE_WR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld && acc_wr && (acc_size != 2'd0)) |=> $stable(fields)); // R6
    AST_UNIMPL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        unimpl_pulse |-> $past(acc_vld && acc_wr && acc_off && dec_en && (acc_size == 2'd0))); // R8
    AST_FIELDS_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_vld && acc_wr) |=> $stable(fields)); // R9

    logic unused_ok;
    always_comb unused_ok = ^acc_wdata;

endmodule

bind sio_cfg_port sio_cfg_port_chk #(.DW(DW)) i_chk (.*);

// File: tb/test_sio_cfg_port.sv
module test_sio_cfg_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dec_en = 1'b0;
    logic       acc_vld = 1'b0;
    logic       acc_wr = 1'b0;
    logic       acc_off = 1'b0;
    logic [1:0] acc_size = 2'd0;
    logic [7:0] acc_wdata = 8'h00;
    logic       rd_vld, unimpl_pulse;
    logic [7:0] rd_data, fn_sel, fdc_base, lpt_base, com1_base, com2_base;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    sio_cfg_port i_sio_cfg_port (
        .clk(clk), .rst_n(rst_n), .dec_en(dec_en), .acc_vld(acc_vld),
        .acc_wr(acc_wr), .acc_off(acc_off), .acc_size(acc_size),
        .acc_wdata(acc_wdata), .rd_vld(rd_vld), .rd_data(rd_data),
        .unimpl_pulse(unimpl_pulse), .fn_sel(fn_sel), .fdc_base(fdc_base),
        .lpt_base(lpt_base), .com1_base(com1_base), .com2_base(com2_base)
    );

    // Behavioural reference model, written from the requirements.
    int  mdl [256];
    int  e_rd = 0;
    bit  e_rv = 0, e_un = 0, started = 0;

    function automatic bit is_defined(int a);
        return a == 0 || a == 'hE0 || a == 'hE1 || a == 'hE2 || a == 'hE3 ||
               a == 'hE6 || a == 'hE7 || a == 'hE8;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (mdl[i]) mdl[i] = 0;
            mdl['hE0] = 'h3C; mdl['hE2] = 'h03; mdl['hE3] = 'hFC;
            mdl['hE6] = 'hDE; mdl['hE7] = 'hFE; mdl['hE8] = 'hBE;
            e_rd = 0; e_rv = 0; e_un = 0; started = 1;
        end else begin
            bit ok;
            int t;
            ok   = dec_en && acc_vld && acc_size == 2'd0;
            e_rv = acc_vld && !acc_wr;
            e_un = 0;
            t    = mdl[0];
            if (acc_vld && !acc_wr) begin
                if (!ok) e_rd = 'hFF;
                else if (!acc_off) e_rd = t;
                else e_rd = (t == 0) ? 0 : mdl[t];
            end
            if (ok && acc_wr) begin
                if (!acc_off) mdl[0] = acc_wdata;
                else if (t != 'hE0 && t != 'hE1) begin
                    mdl[t] = acc_wdata;
                    e_un = !is_defined(t);
                end
            end
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Compare against the model on every clock, away from the active edge.
    always @(negedge clk) begin
        if (started && rst_n && !done) begin
            chk("R3", "rd_vld", rd_vld, e_rv);
            chk("R3", "rd_data", rd_data, e_rd);
            chk("R8", "unimpl_pulse", unimpl_pulse, e_un);
            chk("R9", "fn_sel", fn_sel, mdl['hE2]);
            chk("R9", "fdc_base", fdc_base, mdl['hE3]);
            chk("R9", "lpt_base", lpt_base, mdl['hE6]);
            chk("R9", "com1_base", com1_base, mdl['hE7]);
            chk("R9", "com2_base", com2_base, mdl['hE8]);
        end
    end

    task automatic acc(bit wr, bit off, logic [7:0] d, logic [1:0] sz = 2'd0);
        @(negedge clk);
        acc_vld = 1; acc_wr = wr; acc_off = off; acc_wdata = d; acc_size = sz;
        @(negedge clk);
        acc_vld = 0; acc_wr = 0; acc_size = 2'd0;
    endtask

    task automatic rd(string req, bit off, int exp, logic [1:0] sz = 2'd0);
        acc(0, off, 8'h00, sz);
        chk(req, "read", rd_data, exp);
    endtask

    task automatic finish_run();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] lf;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1", "fn_sel reset", fn_sel, 'h03);
        chk("R1", "fdc reset", fdc_base, 'hFC);
        chk("R1", "lpt reset", lpt_base, 'hDE);
        chk("R1", "com1 reset", com1_base, 'hFE);
        chk("R1", "com2 reset", com2_base, 'hBE);
        chk("R1", "rd_vld reset", rd_vld, 0);
        // R7: disabled decode
        rd("R7", 0, 'hFF);
        acc(1, 0, 8'hE7);
        acc(1, 1, 8'h11);
        chk("R7", "com1 after disabled write", com1_base, 'hFE);
        dec_en = 1;
        rd("R7", 0, 'h00);
        // R2 / R4
        rd("R4", 1, 'h00);
        acc(1, 0, 8'hE0);
        rd("R2", 0, 'hE0);
        rd("R1", 1, 'h3C);
        // R5 read-only
        acc(1, 1, 8'h55);
        rd("R5", 1, 'h3C);
        acc(1, 0, 8'hE1);
        acc(1, 1, 8'h77);
        rd("R5", 1, 'h00);
        // R3 / R9
        acc(1, 0, 8'hE2);
        acc(1, 1, 8'h1C);
        chk("R9", "fn_sel", fn_sel, 'h1C);
        rd("R3", 1, 'h1C);
        // R8 undefined storage
        acc(1, 0, 8'h40);
        acc(1, 1, 8'hA5);
        chk("R8", "pulse", unimpl_pulse, 1);
        @(negedge clk);
        chk("R8", "pulse gone", unimpl_pulse, 0);
        rd("R8", 1, 'hA5);
        // R4 data write at index 0 replaces index
        acc(1, 0, 8'h00);
        acc(1, 1, 8'hE7);
        rd("R4", 0, 'hE7);
        rd("R4", 1, 'hFE);
        // R6 wrong sizes
        acc(1, 0, 8'h10, 2'd1);
        rd("R6", 0, 'hE7);
        acc(1, 1, 8'h00, 2'd2);
        chk("R6", "com1 after dword", com1_base, 'hFE);
        rd("R6", 1, 'hFF, 2'd1);
        // R7 disabled write keeps index
        dec_en = 0;
        acc(1, 0, 8'h33);
        dec_en = 1;
        rd("R7", 0, 'hE7);
        // Pseudo-random traffic; the model compare covers every clock.
        lf = 8'h5A;
        for (int i = 0; i < 400; i++) begin
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            dec_en = (i % 11) != 0;
            acc(lf[0], lf[1], (lf[2] ? {4'hE, lf[7:4]} : lf), (i % 13 == 0) ? 2'd1 : 2'd0);
        end
        dec_en = 1;
        acc(1, 0, 8'hE8);
        acc(1, 1, 8'h2F);
        chk("R9", "com2_base", com2_base, 'h2F);
        @(negedge clk);
        finish_run();
    end

endmodule